// File: doc/BRIEF.md
# Thermometer-to-Binary Gray Encoder

This block turns the thermometer word from a bank of flash-converter comparators into a binary sample code. An intermediate Gray word sits between the comparator inputs and the binary result. Every comparator bit feeds exactly one Gray bit, so an undecided or wrong comparator can disturb only that one bit. It cannot cause several gates to read the same comparator differently.

The Gray word is registered first. A combinational XOR chain then turns it into binary, and the binary result is registered on the output. With the default settings a sample appears two clock edges after it is presented. A valid flag follows the same two-stage pipeline out of reset. The output width `OUT_W` sets the number of comparator inputs to 2^OUT_W - 1 (7 inputs and 3 output bits by default). The parameter `GRAY_PIPE` can remove the Gray register and leave a single stage.

Top module: `thermo_gray_enc`

## Requirements
- R1: Input bit n-1 carries comparator n, with bit 0 the lowest threshold. A legal code has ones in bits 0..k-1 and zeros above them, and it yields bin_out = k.
- R2: An all-zero input yields bin_out = 0. An all-ones input yields bin_out = 2^OUT_W - 1 (7 by default).
- R3: An input with exactly its lower 2^(OUT_W-1) bits set (four ones by default) gives a registered Gray word with only its top two bits set (110) and gives bin_out with only its top bit set (100).
- R4: An input sampled at one rising edge reaches bin_out at the next rising edge, two edges in total. bin_out does not show it after the first edge.
- R5: When the input changes in one bit between consecutive samples, the registered Gray word changes in at most one bit. Seen at the ports, gray(bin_out) changes in at most one bit, where gray(x) = x XOR (x >> 1).
- R6: For an input equal to legal code k with any one bit inverted, gray(bin_out) differs from gray(k) in at most one bit position.
- R7: Reset is synchronous and active high. Each rising edge with rst high leaves bin_out = 0 and out_valid = 0.
- R8: After reset is released, out_valid is still 0 after the first rising edge with rst low. It is 1 after the second such edge and stays 1 until rst is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thermo_in | input | 2^OUT_W - 1 | Comparator outputs; bit 0 is the lowest threshold |
| bin_out | output | OUT_W | Registered binary sample code |
| out_valid | output | 1 | High once the pipeline holds post-reset samples |

## Verification
The hard situation is a corrupted thermometer word, one that no real ladder yields in steady state. For such a word the exact binary value depends on which Gray pair the bad bit belongs to. The stimulus therefore pairs every legal code with each of its single-bit inversions, presented back to back. This exercises both the distance to the correct code and the one-bit change between consecutive samples, and both are judged through the Gray form of the output rather than through an exact value. A reset in the middle of a stream, with a non-zero output pending, shows that the clear and the valid refill are tied to the edges and not to the data.

// File: rtl/thermo_gray_pkg.sv
package thermo_gray_pkg;

  // Reflected binary code of a value.
  function automatic int unsigned bin2gray(input int unsigned v);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/tge_therm2gray.sv
// Maps a thermometer word onto a Gray word. Comparator n (1-based) feeds
// the Gray bit given by the number of trailing zeros of n, so each input
// has fan-out one.
module tge_therm2gray #(
  parameter int OUT_W = 3,
  localparam int THR_N = (1 << OUT_W) - 1
) (
  input  logic [THR_N-1:0] therm_i,
  output logic [OUT_W-1:0] gray_o
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i == OUT_W - 1) begin : g_msb
      assign gray_o[i] = therm_i[(1 << i) - 1];
    end else begin : g_pairs
      localparam int NPAIR = 1 << (OUT_W - 2 - i);
      logic [NPAIR-1:0] window;
      for (genvar k = 0; k < NPAIR; k++) begin : g_win
        // Rising edge of the window at comparator LO, falling at HI (1-based).
        localparam int LO = (1 << i) + k * (1 << (i + 2));
        localparam int HI = LO + (1 << (i + 1));
        assign window[k] = therm_i[LO-1] & ~therm_i[HI-1];
      end
      assign gray_o[i] = |window;
    end
  end

endmodule

// File: rtl/tge_gray2bin.sv
// Gray to binary: each bit is the XOR of all Gray bits at or above it.
module tge_gray2bin #(
  parameter int OUT_W = 3
) (
  input  logic [OUT_W-1:0] gray_i,
  output logic [OUT_W-1:0] bin_o
);

  assign bin_o[OUT_W-1] = gray_i[OUT_W-1];
  for (genvar i = OUT_W - 2; i >= 0; i--) begin : g_chain
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end

endmodule

// File: rtl/tge_stage.sv
// One pipeline stage with synchronous clear; REG = 0 makes it a wire.
module tge_stage #(
  parameter int WIDTH = 1,
  parameter bit REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (REG) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/thermo_gray_enc.sv
module thermo_gray_enc
  import thermo_gray_pkg::*;
#(
  parameter int OUT_W     = 3,
  parameter bit GRAY_PIPE = 1'b1,
  localparam int THR_N    = (1 << OUT_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_N-1:0] thermo_in,
  output logic [OUT_W-1:0] bin_out,
  output logic             out_valid
);

  localparam int HALF_N = 1 << (OUT_W - 1);
  localparam logic [THR_N-1:0] HALF_CODE = {{(THR_N - HALF_N){1'b0}}, {HALF_N{1'b1}}};
  localparam logic [OUT_W-1:0] HALF_GRAY = OUT_W'(bin2gray(HALF_N));

  logic [OUT_W-1:0] gray_c, gray_q, bin_c;
  logic             vld_q;

  tge_therm2gray #(.OUT_W(OUT_W)) u_t2g (
    .therm_i (thermo_in),
    .gray_o  (gray_c)
  );

  tge_stage #(.WIDTH(OUT_W), .REG(GRAY_PIPE)) u_gray_reg (
    .clk (clk), .rst (rst), .d (gray_c), .q (gray_q)
  );

  tge_stage #(.WIDTH(1), .REG(GRAY_PIPE)) u_vld_reg (
    .clk (clk), .rst (rst), .d (1'b1), .q (vld_q)
  );

  tge_gray2bin #(.OUT_W(OUT_W)) u_g2b (
    .gray_i (gray_q),
    .bin_o  (bin_c)
  );

  tge_stage #(.WIDTH(OUT_W), .REG(1'b1)) u_bin_reg (
    .clk (clk), .rst (rst), .d (bin_c), .q (bin_out)
  );

  tge_stage #(.WIDTH(1), .REG(1'b1)) u_out_vld (
    .clk (clk), .rst (rst), .d (vld_q), .q (out_valid)
  );

  // R7: a reset edge clears the output word and the valid flag.
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (bin_out == '0 && !out_valid));

  // R8: once valid, the flag holds until reset.
  p_valid_holds_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  if (GRAY_PIPE) begin : g_pipe_chk
    // R5: a one-bit input step moves the registered Gray word by at most one bit.
    p_gray_onebit_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $countones(thermo_in ^ $past(thermo_in)) <= 1)
        |=> ($countones(gray_q ^ $past(gray_q)) <= 1));

    // R3: lower half of comparators set gives a Gray word with the top two bits set.
    p_half_gray_r3: assert property (@(posedge clk) disable iff (rst)
      (thermo_in == HALF_CODE) |=> (gray_q == HALF_GRAY));

    // R2: all ones reaches full scale two edges later.
    p_full_scale_r2: assert property (@(posedge clk) disable iff (rst)
      (thermo_in == '1) |=> ##1 (bin_out == '1));

    // R2: all zeros reaches zero two edges later.
    p_zero_scale_r2: assert property (@(posedge clk) disable iff (rst)
      (thermo_in == '0) |=> ##1 (bin_out == '0));

    // R8: the valid flag rises one edge after the first stage fills.
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
      vld_q |=> out_valid);
  end

endmodule

// File: tb/sim_thermo_gray_enc.sv
module sim_thermo_gray_enc;

  localparam int CLK_P = 10;
  localparam int OUT_W = 3;
  localparam int N     = (1 << OUT_W) - 1;
  localparam int LAT   = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     thermo_in = '0;
  logic [OUT_W-1:0] bin_out;
  logic             out_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int prev_out = 0;

  int    q_val[$];
  bit    q_ex[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  thermo_gray_enc #(.OUT_W(OUT_W), .GRAY_PIPE(1'b1)) u0 (
    .clk       (clk),
    .rst       (rst),
    .thermo_in (thermo_in),
    .bin_out   (bin_out),
    .out_valid (out_valid)
  );

  function automatic int bgray(input int x);
    return x ^ (x >> 1);
  endfunction

  function automatic logic [N-1:0] legal(input int k);
    logic [N-1:0] t;
    t = '0;
    for (int j = 0; j < k; j++) t[j] = 1'b1;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Every negedge: compare the output against the sample driven LAT negedges ago,
  // then drive the next sample.
  task automatic tick(input logic [N-1:0] t, input bit ex, input int rv, input string tag);
    int    ev;
    bit    ee;
    string tg;
    int    got;
    @(negedge clk);
    if (q_val.size() == LAT) begin
      ev  = q_val.pop_front();
      ee  = q_ex.pop_front();
      tg  = q_tag.pop_front();
      got = int'(bin_out);
      if (ee) begin
        check(got == ev, tg, got, ev);
      end else begin
        check($countones(bgray(got) ^ bgray(ev)) <= 1, "R6 sparkle within one Gray bit", got, ev);
        check($countones(bgray(got) ^ bgray(prev_out)) <= 1, "R5 one-bit step", got, prev_out);
      end
      check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
      prev_out = got;
    end
    thermo_in = t;
    q_val.push_back(rv);
    q_ex.push_back(ex);
    q_tag.push_back(tag);
  endtask

  task automatic do_reset(input int cyc);
    @(negedge clk);
    rst = 1'b1;
    q_val.delete();
    q_ex.delete();
    q_tag.delete();
    repeat (cyc) @(negedge clk);
    check(bin_out == '0, "R7 reset clears output", int'(bin_out), 0);
    check(out_valid == 1'b0, "R7 reset clears valid", int'(out_valid), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R8 valid low after one edge", int'(out_valid), 0);
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R8 valid high after two edges", int'(out_valid), 1);
  endtask

  initial begin : watchdog
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    do_reset(3);

    // R1: legal codes ascending, descending and in a scrambled order.
    for (int k = 0; k <= N; k++) tick(legal(k), 1'b1, k, "R1 legal code ascending");
    for (int k = N; k >= 0; k--) tick(legal(k), 1'b1, k, "R1 legal code descending");
    for (int i = 0; i <= N; i++) tick(legal((i * 5 + 3) % (N + 1)), 1'b1, (i * 5 + 3) % (N + 1), "R1 legal code scrambled");

    // R2: ends of scale.
    tick('0, 1'b1, 0, "R2 all zeros");
    tick('1, 1'b1, N, "R2 all ones");
    tick('0, 1'b1, 0, "R2 all zeros after ones");

    // R3: lower half set.
    tick(legal((N + 1) / 2), 1'b1, (N + 1) / 2, "R3 half code gives 100");

    // R4: latency of exactly two edges.
    tick('0, 1'b1, 0, "R4 lead-in");
    tick('0, 1'b1, 0, "R4 lead-in");
    tick('1, 1'b1, N, "R4 arrives after second edge");
    @(posedge clk); #1;
    check(bin_out == '0, "R4 not visible after first edge", int'(bin_out), 0);

    // R5/R6: each legal code followed by each of its single-bit inversions.
    for (int k = 0; k <= N; k++) begin
      for (int b = 0; b < N; b++) begin
        logic [N-1:0] bad;
        bad = legal(k);
        bad[b] = ~bad[b];
        tick(legal(k), 1'b1, k, "R1 legal code before sparkle");
        tick(bad, 1'b0, k, "R6 sparkle");
      end
    end

    // R7: reset in mid-stream with a non-zero result pending.
    tick('1, 1'b1, N, "R2 all ones before reset");
    tick('1, 1'b1, N, "R2 all ones before reset");
    tick('1, 1'b1, N, "R2 all ones before reset");
    do_reset(1);
    for (int k = N; k >= 0; k -= 2) tick(legal(k), 1'b1, k, "R1 legal code after reset");

    // Drain the pipeline.
    for (int i = 0; i < LAT; i++) tick('0, 1'b1, 0, "R1 drain");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule